// File: doc/BRIEF.md
# Exception Context Save and Restore Sequencer

This block moves a processor's caller-saved context between the register file and memory when an exception starts and when it ends. When an exception is accepted, it writes an eight-word frame to the stack that was active at that moment. It then reads the handler address from the vector table. Finally it hands control to the handler: it writes a return code into the link-register slot, records the exception number and acknowledges the interrupt controller. On an exception return it checks the return code and reads the frame back from the stack that the code names. It writes each word into the register file, branches to the restored program counter and moves the stack pointer past the frame.

The register file, the instruction fetch and the exception arbitration stay outside the block. The block reaches the register file through one read port and one write port, indexed by frame slot. It reaches memory through a single-port request/ready interface that carries one access per cycle. It tells the fetch unit where to go through a branch pulse. The block holds the processor's mode, handler or thread, and which of the two stack pointers is in use, because stack selection depends on both.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, busy, mem_req, all pulse outputs, ipsr, in_handler and on_psp are all 0 (thread mode on the main stack pointer).
- R2: An accepted entry_req makes exactly eight word writes, one per accepted cycle, to addresses SP-32, SP-28, ... SP-4. Each word is taken from reg_rd_data while reg_rd_idx holds the slot number. The slot numbers are 0=R0, 1=R1, 2=R2, 3=R3, 4=R12, 5=LR, 6=PC, 7=xPSR, so R0 goes to the lowest address and xPSR to the highest.
- R3: The frame goes to the stack in use at acceptance: the process stack when on_psp is 1, otherwise the main stack. That same pointer is rewritten through sp_wr_* with SP-32, where sp_wr_psp=1 selects the process stack.
- R4: Right after the eighth write, one read is made at VEC_BASE + 4*exception number.
- R5: In the cycle after the vector read is accepted, done, branch_en and exc_ack pulse together. branch_addr equals the word read, ipsr equals the exception number, in_handler becomes 1 and on_psp becomes 0.
- R6: Return codes are 0xFFFFFFF1 (handler mode, main stack), 0xFFFFFFF9 (thread mode, main stack) and 0xFFFFFFFD (thread mode, process stack). On entry, the code that matches the pre-entry mode and stack is written into slot 5.
- R7: A return with a valid code makes eight reads from the selected stack, from SP upward. Each word is written to slots 0..7 in order, one cycle after its read is accepted. done and branch_en (to the restored slot-6 word) pulse in the cycle after the last read. At the same time the pointer becomes SP+32, ipsr becomes 0, and the mode and stack selection follow the code.
- R8: A return with any other code pulses fault one cycle later. It makes no memory access and leaves the mode, the stack selection and ipsr unchanged.
- R9: While mem_ready is low, the pending access holds its address, direction and slot, and the sequence does not advance.
- R10: busy is high from the cycle after acceptance until the last access completes. entry_req and ret_req arriving while busy are ignored, and done is low while busy.
- R11: When entry_req and ret_req are both high in an idle cycle, the entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | Start exception entry (sampled when idle) |
| entry_num | input | NUM_W | Number of the accepted exception |
| ret_req | input | 1 | Start exception return (sampled when idle) |
| ret_code | input | 32 | Return code taken from the link register |
| msp_in | input | 32 | Current main stack pointer |
| psp_in | input | 32 | Current process stack pointer |
| reg_rd_idx | output | 3 | Frame slot being read from the register file |
| reg_rd_data | input | 32 | Register file read data for reg_rd_idx |
| reg_wr_en | output | 1 | Register file write strobe |
| reg_wr_idx | output | 3 | Frame slot to write |
| reg_wr_data | output | 32 | Register file write data |
| sp_wr_en | output | 1 | Stack pointer write strobe |
| sp_wr_psp | output | 1 | 1 writes the process stack pointer, 0 the main one |
| sp_wr_data | output | 32 | New stack pointer value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| branch_en | output | 1 | Redirect fetch |
| branch_addr | output | 32 | Fetch target |
| ipsr | output | NUM_W | Active exception number, 0 in thread mode |
| exc_ack | output | 1 | Pulse to the interrupt controller: exception now active |
| in_handler | output | 1 | 1 in handler mode |
| on_psp | output | 1 | 1 when the process stack pointer is in use |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| fault | output | 1 | Invalid return code pulse |

## Verification
The block is exercised along several paths:
- entries from thread mode on each stack and from handler mode (nesting);
- returns with each of the three valid codes;
- one invalid code;
- memory that answers every cycle, and memory that answers one cycle in four.

Entries from the different starting states separate the stack choice and the three return codes from one another. The memory stalls show whether the access order and the frame contents survive back-pressure. A frame is pushed and later popped, and the restored register values are compared with the saved ones, which shows that slot order and address order agree in both directions. Further runs raise requests in the middle of a sequence, and raise entry and return in the same cycle, to test that the ignore and priority rules hold.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam logic [IDX_W-1:0] SLOT_LR   = IDX_W'(5);
  localparam logic [IDX_W-1:0] SLOT_PC   = IDX_W'(6);
  localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(FRAME_WORDS - 1);

  localparam logic [31:0] RET_HANDLER_MAIN = 32'hFFFF_FFF1;
  localparam logic [31:0] RET_THREAD_MAIN  = 32'hFFFF_FFF9;
  localparam logic [31:0] RET_THREAD_PROC  = 32'hFFFF_FFFD;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PUSH,
    SQ_VEC,
    SQ_POP
  } seq_state_t;
endpackage

// File: rtl/exc_ret_decode.sv
module exc_ret_decode (
  input  logic [31:0] code,
  output logic        valid,
  output logic        to_handler,
  output logic        to_psp
);
  import exc_frame_pkg::*;

  always_comb begin
    valid      = 1'b1;
    to_handler = 1'b0;
    to_psp     = 1'b0;
    unique case (code)
      RET_HANDLER_MAIN: to_handler = 1'b1;
      RET_THREAD_MAIN:  ;
      RET_THREAD_PROC:  to_psp = 1'b1;
      default:          valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen #(
  parameter int          NUM_W    = 6,
  parameter int          IDX_W    = 3,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic [31:0]      frame_base,
  input  logic [IDX_W-1:0] slot,
  input  logic [NUM_W-1:0] num,
  input  logic             vec_sel,
  output logic [31:0]      addr
);
  logic [31:0] slot_off;
  logic [31:0] vec_off;

  assign slot_off = 32'(slot) << 2;
  assign vec_off  = 32'(num) << 2;
  assign addr     = vec_sel ? (VEC_BASE + vec_off) : (frame_base + slot_off);
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq #(
  parameter int          NUM_W    = 6,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_req,
  input  logic [NUM_W-1:0] entry_num,
  input  logic             ret_req,
  input  logic [31:0]      ret_code,
  input  logic [31:0]      msp_in,
  input  logic [31:0]      psp_in,
  output logic [2:0]       reg_rd_idx,
  input  logic [31:0]      reg_rd_data,
  output logic             reg_wr_en,
  output logic [2:0]       reg_wr_idx,
  output logic [31:0]      reg_wr_data,
  output logic             sp_wr_en,
  output logic             sp_wr_psp,
  output logic [31:0]      sp_wr_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ready,
  output logic             branch_en,
  output logic [31:0]      branch_addr,
  output logic [NUM_W-1:0] ipsr,
  output logic             exc_ack,
  output logic             in_handler,
  output logic             on_psp,
  output logic             busy,
  output logic             done,
  output logic             fault
);
  import exc_frame_pkg::*;

  seq_state_t       state;
  logic [IDX_W-1:0] slot;
  logic [31:0]      frame_base;
  logic [NUM_W-1:0] num_q;
  logic [31:0]      code_q;
  logic [31:0]      pc_q;
  logic             tgt_handler;
  logic             tgt_psp;
  logic [31:0]      act_sp;
  logic             dec_valid;
  logic             dec_handler;
  logic             dec_psp;

  exc_ret_decode u_dec (
    .code       (ret_code),
    .valid      (dec_valid),
    .to_handler (dec_handler),
    .to_psp     (dec_psp)
  );

  exc_addr_gen #(
    .NUM_W    (NUM_W),
    .IDX_W    (IDX_W),
    .VEC_BASE (VEC_BASE)
  ) u_addr (
    .frame_base (frame_base),
    .slot       (slot),
    .num        (num_q),
    .vec_sel    (state == SQ_VEC),
    .addr       (mem_addr)
  );

  assign act_sp     = on_psp ? psp_in : msp_in;
  assign mem_req    = (state != SQ_IDLE);
  assign mem_we     = (state == SQ_PUSH);
  assign mem_wdata  = reg_rd_data;
  assign reg_rd_idx = slot;
  assign busy       = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      slot        <= '0;
      frame_base  <= '0;
      num_q       <= '0;
      code_q      <= '0;
      pc_q        <= '0;
      tgt_handler <= 1'b0;
      tgt_psp     <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_idx  <= '0;
      reg_wr_data <= '0;
      sp_wr_en    <= 1'b0;
      sp_wr_psp   <= 1'b0;
      sp_wr_data  <= '0;
      branch_en   <= 1'b0;
      branch_addr <= '0;
      ipsr        <= '0;
      exc_ack     <= 1'b0;
      in_handler  <= 1'b0;
      on_psp      <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      sp_wr_en  <= 1'b0;
      branch_en <= 1'b0;
      exc_ack   <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          slot <= '0;
          if (entry_req) begin
            frame_base <= act_sp - 32'(FRAME_BYTES);
            sp_wr_en   <= 1'b1;
            sp_wr_psp  <= on_psp;
            sp_wr_data <= act_sp - 32'(FRAME_BYTES);
            num_q      <= entry_num;
            code_q     <= in_handler ? RET_HANDLER_MAIN :
                          (on_psp ? RET_THREAD_PROC : RET_THREAD_MAIN);
            state      <= SQ_PUSH;
          end else if (ret_req) begin
            if (dec_valid) begin
              frame_base  <= dec_psp ? psp_in : msp_in;
              tgt_handler <= dec_handler;
              tgt_psp     <= dec_psp;
              state       <= SQ_POP;
            end else begin
              fault <= 1'b1;
            end
          end
        end
        SQ_PUSH: begin
          if (mem_ready) begin
            if (slot == SLOT_LAST) state <= SQ_VEC;
            else                   slot  <= slot + 1'b1;
          end
        end
        SQ_VEC: begin
          if (mem_ready) begin
            branch_en   <= 1'b1;
            branch_addr <= mem_rdata;
            reg_wr_en   <= 1'b1;
            reg_wr_idx  <= SLOT_LR;
            reg_wr_data <= code_q;
            ipsr        <= num_q;
            exc_ack     <= 1'b1;
            in_handler  <= 1'b1;
            on_psp      <= 1'b0;
            done        <= 1'b1;
            state       <= SQ_IDLE;
          end
        end
        SQ_POP: begin
          if (mem_ready) begin
            reg_wr_en   <= 1'b1;
            reg_wr_idx  <= slot;
            reg_wr_data <= mem_rdata;
            if (slot == SLOT_PC) pc_q <= mem_rdata;
            if (slot == SLOT_LAST) begin
              branch_en   <= 1'b1;
              branch_addr <= pc_q;
              sp_wr_en    <= 1'b1;
              sp_wr_psp   <= tgt_psp;
              sp_wr_data  <= frame_base + 32'(FRAME_BYTES);
              ipsr        <= '0;
              in_handler  <= tgt_handler;
              on_psp      <= tgt_psp;
              done        <= 1'b1;
              state       <= SQ_IDLE;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ready,
  input logic [2:0]  reg_rd_idx,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        exc_ack,
  input logic        in_handler,
  input logic        on_psp
);
  AST_WRITE_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req); // R2
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(reg_rd_idx))); // R9
  AST_ACK_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    exc_ack |-> (done && in_handler)); // R5
  AST_HANDLER_ON_MAIN: assert property (@(posedge clk) disable iff (rst)
    in_handler |-> !on_psp); // R6
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!busy && !done && !mem_req)); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R10
endmodule

bind exc_frame_seq exc_frame_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ready  (mem_ready),
  .reg_rd_idx (reg_rd_idx),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .exc_ack    (exc_ack),
  .in_handler (in_handler),
  .on_psp     (on_psp)
);

// File: tb/exc_frame_seq_test.sv
`timescale 1ns/1ps
module exc_frame_seq_test;
  localparam int NUM_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             entry_req = 1'b0;
  logic [NUM_W-1:0] entry_num = '0;
  logic             ret_req = 1'b0;
  logic [31:0]      ret_code = '0;
  logic [31:0]      msp_m, psp_m;
  logic [2:0]       reg_rd_idx;
  logic [31:0]      reg_rd_data;
  logic             reg_wr_en;
  logic [2:0]       reg_wr_idx;
  logic [31:0]      reg_wr_data;
  logic             sp_wr_en, sp_wr_psp;
  logic [31:0]      sp_wr_data;
  logic             mem_req, mem_we, mem_ready;
  logic [31:0]      mem_addr, mem_wdata, mem_rdata;
  logic             branch_en;
  logic [31:0]      branch_addr;
  logic [NUM_W-1:0] ipsr;
  logic             exc_ack, in_handler, on_psp, busy, done, fault;

  logic [31:0] regf [8];
  logic [31:0] mem  [256];
  logic        stall_on = 1'b0;
  logic [1:0]  rdy_cnt = '0;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  exc_frame_seq #(.NUM_W(NUM_W), .VEC_BASE(32'h0)) uut (
    .clk(clk), .rst(rst), .entry_req(entry_req), .entry_num(entry_num),
    .ret_req(ret_req), .ret_code(ret_code), .msp_in(msp_m), .psp_in(psp_m),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en),
    .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data), .sp_wr_en(sp_wr_en),
    .sp_wr_psp(sp_wr_psp), .sp_wr_data(sp_wr_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .branch_en(branch_en),
    .branch_addr(branch_addr), .ipsr(ipsr), .exc_ack(exc_ack),
    .in_handler(in_handler), .on_psp(on_psp), .busy(busy), .done(done),
    .fault(fault)
  );

  assign reg_rd_data = regf[reg_rd_idx];
  assign mem_rdata   = mem[mem_addr[9:2]];
  assign mem_ready   = !stall_on || (rdy_cnt == 2'b11);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdy_cnt <= rdy_cnt + 1'b1;
    if (reg_wr_en) regf[reg_wr_idx] <= reg_wr_data;
    if (sp_wr_en) begin
      if (sp_wr_psp) psp_m <= sp_wr_data;
      else           msp_m <= sp_wr_data;
    end
    if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end

  // access and pulse log, sampled away from the clock edge
  logic [31:0] lg_addr [16];
  logic [31:0] lg_data [16];
  logic        lg_we   [16];
  int          lg_cyc  [16];
  int          lg_n = 0;
  int          done_n = 0, done_cyc = 0, ack_cyc = -1, fault_n = 0;
  logic [31:0] br_seen = '0;

  always @(negedge clk) begin
    if (!rst && mem_req && mem_ready && lg_n < 16) begin
      lg_addr[lg_n] <= mem_addr;
      lg_we[lg_n]   <= mem_we;
      lg_data[lg_n] <= mem_we ? mem_wdata : mem_rdata;
      lg_cyc[lg_n]  <= cyc;
      lg_n          <= lg_n + 1;
    end
    if (done) begin done_n <= done_n + 1; done_cyc <= cyc; end
    if (exc_ack) ack_cyc <= cyc;
    if (branch_en) br_seen <= branch_addr;
    if (fault) fault_n <= fault_n + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    lg_n = 0; done_n = 0; ack_cyc = -1; fault_n = 0; br_seen = '0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && done_n == 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_entry(input int num, input bit stall, input logic [31:0] exp_code,
                           input bit noise, input bit both);
    logic [31:0] saved [8];
    logic        src_psp;
    logic [31:0] base;
    src_psp = on_psp;
    base = (src_psp ? psp_m : msp_m) - 32;
    for (int i = 0; i < 8; i++) begin
      regf[i] = 32'hA000_0000 + (num << 8) + i;
      saved[i] = regf[i];
    end
    clr_log();
    stall_on = stall;
    entry_req = 1'b1; entry_num = NUM_W'(num);
    if (both) begin ret_req = 1'b1; ret_code = 32'hFFFF_FFF9; end
    @(negedge clk);
    entry_req = 1'b0; ret_req = 1'b0;
    if (noise) begin
      @(negedge clk);
      entry_req = 1'b1; ret_req = 1'b1; ret_code = 32'hFFFF_FFF1;
      @(negedge clk);
      entry_req = 1'b0; ret_req = 1'b0;
    end
    wait_done();
    stall_on = 1'b0;
    check("R2 access count", 32'(lg_n), 32'd9);
    check("R11/R2 first access is a write", 32'(lg_we[0]), 32'd1);
    for (int i = 0; i < 8; i++) begin
      check("R2 push address", lg_addr[i], base + 32'(4 * i));
      check("R2 push data", lg_data[i], saved[i]);
      check("R9 stored word", mem[lg_addr[i][9:2]], saved[i]);
    end
    check("R4 vector read dir", 32'(lg_we[8]), 32'd0);
    check("R4 vector address", lg_addr[8], 32'(4 * num));
    check("R5 done timing", 32'(done_cyc), 32'(lg_cyc[8] + 1));
    check("R5 ack with done", 32'(ack_cyc), 32'(done_cyc));
    check("R10 single done", 32'(done_n), 32'd1);
    check("R5 branch target", br_seen, 32'h1000 + 32'(num * 16));
    check("R5 ipsr", 32'(ipsr), 32'(num));
    check("R5 handler mode", {in_handler, on_psp}, 32'b10);
    check("R6 return code in LR", regf[5], exp_code);
    check("R3 stack pointer", src_psp ? psp_m : msp_m, base);
    check("R10 idle after", 32'(busy), 32'd0);
  endtask

  task automatic run_return(input logic [31:0] code, input bit stall,
                            input bit exp_h, input bit exp_p);
    logic [31:0] frame [8];
    logic [31:0] base;
    base = exp_p ? psp_m : msp_m;
    for (int i = 0; i < 8; i++) frame[i] = mem[(base[9:2]) + 8'(i)];
    clr_log();
    stall_on = stall;
    ret_req = 1'b1; ret_code = code;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done();
    stall_on = 1'b0;
    check("R7 access count", 32'(lg_n), 32'd8);
    for (int i = 0; i < 8; i++) begin
      check("R7 pop address", lg_addr[i], base + 32'(4 * i));
      check("R7 pop is read", 32'(lg_we[i]), 32'd0);
      check("R7 restored slot", regf[i], frame[i]);
    end
    check("R7 done timing", 32'(done_cyc), 32'(lg_cyc[7] + 1));
    check("R7 branch to PC", br_seen, frame[6]);
    check("R7 stack pointer", exp_p ? psp_m : msp_m, base + 32);
    check("R7 ipsr cleared", 32'(ipsr), 32'd0);
    check("R6 mode after return", {in_handler, on_psp}, {30'd0, exp_h, exp_p});
  endtask

  task automatic run_bad_code();
    logic [NUM_W-1:0] ip0;
    logic             h0, p0;
    ip0 = ipsr; h0 = in_handler; p0 = on_psp;
    clr_log();
    ret_req = 1'b1; ret_code = 32'hFFFF_FFE9;
    @(negedge clk);
    ret_req = 1'b0;
    check("R8 fault pulse", 32'(fault), 32'd1);
    repeat (3) @(negedge clk);
    check("R8 one fault", 32'(fault_n), 32'd1);
    check("R8 no access", 32'(lg_n), 32'd0);
    check("R8 no done", 32'(done_n), 32'd0);
    check("R8 state kept", {ipsr, in_handler, on_psp}, {ip0, h0, p0});
  endtask

  initial begin
    msp_m = 32'h300; psp_m = 32'h1E0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000 + 32'(i * 16);
    for (int i = 0; i < 8; i++) begin
      regf[i] = '0;
      mem[(32'h1E0 >> 2) + i] = 32'hC0DE_0000 + 32'(i);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset mem_req", 32'(mem_req), 32'd0);
    check("R1 reset pulses", {done, fault, exc_ack, branch_en, reg_wr_en, sp_wr_en}, 32'd0);
    check("R1 reset ipsr/mode", {ipsr, in_handler, on_psp}, 32'd0);

    run_entry(3, 1'b0, 32'hFFFF_FFF9, 1'b0, 1'b0);  // thread/main
    run_entry(5, 1'b1, 32'hFFFF_FFF1, 1'b0, 1'b0);  // nested, stalled
    run_return(32'hFFFF_FFF1, 1'b1, 1'b1, 1'b0);
    run_return(32'hFFFF_FFF9, 1'b0, 1'b0, 1'b0);
    run_bad_code();
    run_return(32'hFFFF_FFFD, 1'b0, 1'b0, 1'b1);    // R6 onto process stack
    run_entry(7, 1'b0, 32'hFFFF_FFFD, 1'b0, 1'b0);  // R3 frame on process stack
    run_entry(9, 1'b1, 32'hFFFF_FFF1, 1'b1, 1'b0);  // R10 noise while busy
    run_return(32'hFFFF_FFF1, 1'b0, 1'b1, 1'b0);
    run_return(32'hFFFF_FFFD, 1'b1, 1'b0, 1'b1);
    run_entry(12, 1'b0, 32'hFFFF_FFFD, 1'b0, 1'b1); // R11 both requests
    run_return(32'hFFFF_FFFD, 1'b0, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule